// File: doc/BRIEF.md
# Prefix Byte Operand Classifier

This block sits at the front of an instruction decoder that handles variable-length instructions. It accepts bytes from a stream with a valid/ready handshake. From the first byte it works out what kind of operand the instruction uses: a memory operand that is read (source), a memory operand that is written (destination), or a register operand. It also works out the operand width. Where the encoding calls for more bytes, the block pulls them in: one signed displacement, a direct address of one to three bytes, or a full register code.

While it accepts the first byte, the block reads a 32-bit base register through a small read port. It then forms the effective address, or the register selection. Once the operand is settled, it accepts exactly one more byte, the operation byte, and presents the whole result on a held output until the consumer takes it. First bytes that are not prefixes, undefined, or outside this block's scope are reported at once, and no more bytes are taken for them.

Top module: `prefix_operand_classifier`

## Requirements
- R1: A first byte below 0x80 gives kind 0 (none), with the illegal and unsupported flags clear. No further byte is taken, and the result is valid the cycle after the byte is accepted.
- R2: First bytes 0x80–0xAF give kind 1 (source memory) with size code bits 5:4 (0 means 8-bit, 1 means 16-bit, 2 means 32-bit). `rd_idx` carries bits 2:0 during the accept. With bit 3 clear, no address byte follows and the address equals the base register value.
- R3: For first bytes 0x80–0xBF with bit 3 set, one displacement byte follows. It is sign-extended to 32 bits and added to the base value, and the sum wraps modulo 2^32.
- R4: First bytes 0xB0–0xBF give kind 3 (destination memory) with size code 3 (unsized). They use the same base-register and displacement addressing as R2 and R3.
- R5: First bytes 0xC0–0xC2, 0xD0–0xD2 and 0xE0–0xE2 give kind 1 with size code 0, 1 and 2 respectively. First bytes 0xF0–0xF2 give kind 3 with size code 3. A low nibble of 0, 1 or 2 means that 1, 2 or 3 direct-address bytes follow, least significant first, and the address is that value zero-extended.
- R6: First bytes 0xC8–0xCF, 0xD8–0xDF and 0xE8–0xEF give kind 2 (register) with size code 0, 1 and 2. `res_reg` equals bits 2:0, `res_reg_long` is 0, no extra byte is taken, and `res_addr` is 0.
- R7: First bytes 0xC7, 0xD7 and 0xE7 give kind 2 with size code 0, 1 and 2. The next byte is output unchanged as `res_reg`, `res_reg_long` is 1, and `res_addr` is 0.
- R8: First bytes 0xC6, 0xD6 and 0xE6 set `res_illegal`, give kind 0, and take no further byte.
- R9: Every other first byte of 0xC0 or above sets `res_unsup`, gives kind 0, and takes no further byte. These are 0xC3–0xC5, 0xD3–0xD5, 0xE3–0xE5 and 0xF3–0xFF.
- R10: After the operand bytes of a kind 1, 2 or 3 result, exactly one operation byte is taken and output as `res_op` (`res_op` is 0 for kind 0). While `res_valid` is high, `in_ready` is low and all result outputs hold steady until `res_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte |
| rd_idx | output | 3 | Base register index for the read port |
| rd_data | input | 32 | Base register value (combinational read) |
| res_valid | output | 1 | Result held and valid |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 none, 1 source memory, 2 register, 3 destination memory |
| res_size | output | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 unsized |
| res_addr | output | 32 | Effective address for memory kinds |
| res_reg | output | 8 | Register index or full register code |
| res_reg_long | output | 1 | res_reg holds a full code from a separate byte |
| res_op | output | 8 | Operation byte that follows the operand |
| res_illegal | output | 1 | Undefined first byte |
| res_unsup | output | 1 | First byte outside this block's scope |

## Verification
The assertions take two things for granted. First, `rd_data` is a pure function of `rd_idx` within the accept cycle. Second, `res_ready` may be held low for any time, with no timing limit of its own. The stimulus keeps within both. It drives `rd_data` from a fixed table indexed by `rd_idx`. It stalls `res_ready` for zero to three cycles, and it only raises `in_valid` on a falling edge. The byte sequences always follow the expected byte count. An over-eager or starved byte count therefore shows up as `res_valid` failing to rise in the expected cycle, not as a protocol violation.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 32;
  localparam int MAX_EXTRA = 3;
  localparam int CNT_W = $clog2(MAX_EXTRA + 1);
  localparam int ACC_W = MAX_EXTRA * BYTE_W;

  typedef enum logic [1:0] {
    K_NONE = 2'd0, K_SRC = 2'd1, K_REG = 2'd2, K_DST = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    AM_NONE, AM_BASE, AM_BASE_DISP, AM_DIRECT, AM_REG_SHORT, AM_REG_LONG
  } amode_e;

  typedef struct packed {
    kind_e              kind;
    logic [1:0]         size;
    amode_e             mode;
    logic [CNT_W-1:0]   nextra;
    logic               needs_op;
    logic               illegal;
    logic               unsup;
  } dec_t;

  function automatic dec_t classify(input logic [BYTE_W-1:0] b);
    dec_t d;
    logic [1:0] grp;
    logic [3:0] lo;
    d = '{kind: K_NONE, size: 2'd0, mode: AM_NONE, nextra: '0,
          needs_op: 1'b0, illegal: 1'b0, unsup: 1'b0};
    grp = b[5:4];
    lo  = b[3:0];
    if (!b[7]) begin
      d.kind = K_NONE;
    end else if (!b[6]) begin
      d.kind     = (grp == 2'd3) ? K_DST : K_SRC;
      d.size     = grp;
      d.mode     = b[3] ? AM_BASE_DISP : AM_BASE;
      d.nextra   = CNT_W'(b[3]);
      d.needs_op = 1'b1;
    end else if (lo <= 4'd2) begin
      d.kind     = (grp == 2'd3) ? K_DST : K_SRC;
      d.size     = grp;
      d.mode     = AM_DIRECT;
      d.nextra   = CNT_W'(lo) + CNT_W'(1);
      d.needs_op = 1'b1;
    end else if (grp == 2'd3) begin
      d.unsup = 1'b1;
    end else if (lo == 4'd7) begin
      d.kind     = K_REG;
      d.size     = grp;
      d.mode     = AM_REG_LONG;
      d.nextra   = CNT_W'(1);
      d.needs_op = 1'b1;
    end else if (lo[3]) begin
      d.kind     = K_REG;
      d.size     = grp;
      d.mode     = AM_REG_SHORT;
      d.needs_op = 1'b1;
    end else if (lo == 4'd6) begin
      d.illegal = 1'b1;
    end else begin
      d.unsup = 1'b1;
    end
    return d;
  endfunction

  function automatic logic [ADDR_W-1:0] sext_byte(input logic [BYTE_W-1:0] v);
    return {{(ADDR_W-BYTE_W){v[BYTE_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] eff_addr(input amode_e m,
                                                 input logic [ADDR_W-1:0] base,
                                                 input logic [ACC_W-1:0] acc);
    case (m)
      AM_BASE:      return base;
      AM_BASE_DISP: return base + sext_byte(acc[BYTE_W-1:0]);
      AM_DIRECT:    return ADDR_W'(acc);
      default:      return '0;
    endcase
  endfunction
endpackage

// File: rtl/pbc_decode.sv
module pbc_decode
  import pbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] first_byte,
  output dec_t              dec
);
  assign dec = classify(first_byte);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.illegal, dec.unsup, dec.needs_op})); // R8
  AST_FLAG_NO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.illegal || dec.unsup) |-> (dec.kind == K_NONE && dec.nextra == '0)); // R9
endmodule

// File: rtl/pbc_accum.sv
module pbc_accum
  import pbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              shift_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic [CNT_W-1:0]  cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      base_q <= base_in;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (shift_en) begin
      acc_q[cnt_q*BYTE_W +: BYTE_W] <= byte_in;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> cnt_q < CNT_W'(MAX_EXTRA)); // R5
endmodule

// File: rtl/prefix_operand_classifier.sv
module prefix_operand_classifier
  import pbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic [2:0]  rd_idx,
  input  logic [31:0] rd_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [1:0]  res_kind,
  output logic [1:0]  res_size,
  output logic [31:0] res_addr,
  output logic [7:0]  res_reg,
  output logic        res_reg_long,
  output logic [7:0]  res_op,
  output logic        res_illegal,
  output logic        res_unsup
);
  typedef enum logic [1:0] {S_FIRST, S_EXTRA, S_OPER, S_HOLD} state_e;

  state_e            state_q;
  dec_t              dec_now, dec_q;
  logic [BYTE_W-1:0] first_q, op_q;
  logic [ADDR_W-1:0] base_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  cnt_q;

  logic take;
  logic first_take;
  logic extra_take;
  logic oper_take;
  logic res_take;
  logic last_extra;

  assign in_ready   = (state_q != S_HOLD);
  assign take       = in_valid && in_ready;
  assign first_take = take && state_q == S_FIRST;
  assign extra_take = take && state_q == S_EXTRA;
  assign oper_take  = take && state_q == S_OPER;
  assign res_take   = res_valid && res_ready;
  assign last_extra = (cnt_q + CNT_W'(1)) == dec_q.nextra;
  assign rd_idx     = in_data[2:0];

  pbc_decode u_decode (
    .clk(clk), .rst_n(rst_n), .first_byte(in_data), .dec(dec_now)
  );

  pbc_accum u_accum (
    .clk(clk), .rst_n(rst_n),
    .start(first_take), .base_in(rd_data),
    .shift_en(extra_take), .byte_in(in_data),
    .base_q(base_q), .acc_q(acc_q), .cnt_q(cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FIRST;
      dec_q   <= '0;
      first_q <= '0;
      op_q    <= '0;
    end else begin
      case (state_q)
        S_FIRST: if (first_take) begin
          dec_q   <= dec_now;
          first_q <= in_data;
          op_q    <= '0;
          if (dec_now.nextra != '0)  state_q <= S_EXTRA;
          else if (dec_now.needs_op) state_q <= S_OPER;
          else                       state_q <= S_HOLD;
        end
        S_EXTRA: if (extra_take && last_extra) state_q <= S_OPER;
        S_OPER: if (oper_take) begin
          op_q    <= in_data;
          state_q <= S_HOLD;
        end
        default: if (res_take) state_q <= S_FIRST;
      endcase
    end
  end

  assign res_valid    = (state_q == S_HOLD);
  assign res_kind     = dec_q.kind;
  assign res_size     = dec_q.size;
  assign res_addr     = eff_addr(dec_q.mode, base_q, acc_q);
  assign res_reg_long = (dec_q.mode == AM_REG_LONG);
  assign res_reg      = (dec_q.mode == AM_REG_SHORT) ? {5'd0, first_q[2:0]} :
                        (dec_q.mode == AM_REG_LONG)  ? acc_q[BYTE_W-1:0] : 8'd0;
  assign res_op       = op_q;
  assign res_illegal  = dec_q.illegal;
  assign res_unsup    = dec_q.unsup;

  AST_NOPFX_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (first_take && !in_data[7]) |=> res_valid); // R1
  AST_ILLEGAL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (first_take && dec_now.illegal) |=> (res_valid && res_illegal)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
      $stable(res_op) && $stable(res_reg) && $stable(res_kind))); // R10
  AST_HOLD_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready); // R10
  AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_REG) |-> (res_addr == '0 && res_size != 2'd3)); // R6
  AST_KIND_NONE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_NONE) |-> res_op == 8'd0); // R10
endmodule

// File: tb/prefix_operand_classifier_tb.sv
module prefix_operand_classifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        in_ready;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_kind, res_size;
  logic [31:0] res_addr;
  logic [7:0]  res_reg, res_op;
  logic        res_reg_long, res_illegal, res_unsup;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] regval(input logic [2:0] i);
    return i[0] ? (32'hFFFF_FFF0 + {29'd0, i}) : (32'h1234_5600 + 32'h0101_0000 * i);
  endfunction
  assign rd_data = regval(rd_idx);

  prefix_operand_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_idx(rd_idx), .rd_data(rd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
    .res_size(res_size), .res_addr(res_addr), .res_reg(res_reg),
    .res_reg_long(res_reg_long), .res_op(res_op),
    .res_illegal(res_illegal), .res_unsup(res_unsup)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_vec(input int f, input int pass);
    int kind, size, nex, op, ill, uns, mode, hold;
    logic [7:0] ex [3];
    logic [7:0] opb;
    logic [31:0] eaddr;
    logic [7:0] ereg;
    int elong;
    string req;
    kind = 0; size = 0; nex = 0; op = 0; ill = 0; uns = 0; mode = 0;
    if (f < 128) req = "R1";
    else if (f < 176) begin
      kind = 1; size = (f - 128) / 16; op = 1;
      mode = ((f % 16) >= 8) ? 2 : 1; nex = mode - 1;
      req = (mode == 2) ? "R3" : "R2";
    end else if (f < 192) begin
      kind = 3; size = 3; op = 1; mode = ((f % 16) >= 8) ? 2 : 1;
      nex = mode - 1; req = "R4";
    end else if ((f % 16) < 3) begin
      kind = (f >= 240) ? 3 : 1; size = (f - 192) / 16; op = 1;
      mode = 3; nex = (f % 16) + 1; req = "R5";
    end else if (f >= 240) begin
      uns = 1; req = "R9";
    end else if ((f % 16) == 7) begin
      kind = 2; size = (f - 192) / 16; op = 1; mode = 5; nex = 1; req = "R7";
    end else if ((f % 16) >= 8) begin
      kind = 2; size = (f - 192) / 16; op = 1; mode = 4; req = "R6";
    end else if ((f % 16) == 6) begin
      ill = 1; req = "R8";
    end else begin
      uns = 1; req = "R9";
    end
    for (int k = 0; k < 3; k++) ex[k] = 8'((f * 7 + k * 91 + pass * 128) & 255);
    opb = 8'((f * 13 + 5 + pass) & 255);
    eaddr = 32'd0; ereg = 8'd0; elong = 0;
    case (mode)
      1: eaddr = regval(3'(f % 8));
      2: eaddr = regval(3'(f % 8)) + ((ex[0] >= 128) ? (32'(ex[0]) - 32'd256) : 32'(ex[0]));
      3: eaddr = 32'(ex[0]) + (nex > 1 ? 32'(ex[1]) * 256 : 0) + (nex > 2 ? 32'(ex[2]) * 65536 : 0);
      4: ereg = 8'(f % 8);
      5: begin ereg = ex[0]; elong = 1; end
      default: ;
    endcase
    send(8'(f));
    for (int k = 0; k < nex; k++) send(ex[k]);
    if (op != 0) send(opb);
    @(negedge clk);
    check(req, "res_valid on time", 32'(res_valid), 32'd1);
    hold = (f + pass) % 4;
    for (int h = 0; h < hold; h++) begin
      check("R10", "in_ready low while held", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    check(req, "kind", 32'(res_kind), 32'(kind));
    check(req, "size", 32'(res_size), 32'(size));
    check(req, "addr", res_addr, eaddr);
    check(req, "reg", 32'(res_reg), 32'(ereg));
    check(req, "reg_long", 32'(res_reg_long), 32'(elong));
    check("R10", "op byte", 32'(res_op), op ? 32'(opb) : 32'd0);
    check(req, "illegal", 32'(res_illegal), 32'(ill));
    check(req, "unsup", 32'(res_unsup), 32'(uns));
    res_ready = 1'b1;
    @(posedge clk);
    #1 res_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset res_valid", 32'(res_valid), 32'd0);
    check("R10", "reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++)
      for (int f = 0; f < 256; f++) run_vec(f, pass);
    @(negedge clk);
    check("R10", "idle after sweep", 32'(res_valid), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule